// File: doc/BRIEF.md
# Timer Master Trigger Selector

This block is a 16-bit up-counting timer with one trigger output. The output lets a second timer follow this one. A 3-bit selector in the control register chooses what appears on the trigger output. The choices are the software restart strobe, the effective counter enable, the update event, a compare-match pulse, or one of four compare reference levels. Because the update event can be routed to the output, a second timer can use this one as a clock divider.

An external trigger pin has a programmable polarity. The pin can gate the counter, letting it run only while the pin is active. It can also restart the counter on each activating edge. When the counter enable comes from the pin, the trigger output reports that enable one cycle late. An optional alignment bit delays the counter's own view of the pin by the same cycle, so that the counter and a slave timer start together.

Software reaches the block through a one-cycle write port. Address 0 holds the control fields. Address 1 is the restart strobe. Address 2 holds the wrap limit. Addresses 4 to 7 hold the compare values for channels 0 to 3.

Top module: `timer_trgo_sel`

## Requirements
- R1: After reset the counter is 0, the wrap limit is all ones, the compare values are 0 and the control fields are 0. As a result, `trgo` and every `oc_ref` bit are low.
- R2: Writes take effect at the clock edge on which `wr_en` is high. At address 0 the fields are: bit 0 is the software run bit, bits 3:1 are the output selector, bit 4 is the alignment bit, bits 6:5 are the pin mode (01 restart, 10 gate, 00 or 11 off) and bit 7 is the pin invert bit. Address 1 bit 0 is the restart strobe. Address 2 is the wrap limit. Address 4+i is the compare value of channel i.
- R3: While enabled, the counter steps up by one per cycle. In the cycle it equals the wrap limit, it raises a one-cycle update event and goes to 0 on the next edge. With selector 010, `trgo` therefore pulses exactly once every (limit+1) enabled cycles.
- R4: Writing 1 to the restart strobe gives a one-cycle strobe that clears itself. The strobe clears the counter on the following edge and also counts as an update event. If it falls in the same cycle as a wrap, it produces only one update pulse. With selector 000, `trgo` carries this strobe.
- R5: `oc_ref[i]` is high exactly while the counter is below compare value i. Selectors 100 to 111 put channels 0 to 3 on `trgo`.
- R6: With selector 011, `trgo` gives a one-cycle pulse in every enabled cycle in which the counter equals the channel 0 compare value. It pulses again on each later match, with no state held between matches.
- R7: In gate mode, the counter is enabled by the run bit OR the active pin level. With selector 001, `trgo` shows the run bit OR the pin level registered one cycle earlier, so it lags the counter start by one cycle.
- R8: With the alignment bit set in gate mode, the counter also uses the registered pin level. The counter then starts in the same cycle that `trgo` (selector 001) rises.
- R9: With the invert bit at 0, the pin is active high and its rising edge is the active edge. With the invert bit at 1, the pin is active low and its falling edge is the active edge.
- R10: In restart mode, an active pin edge clears the counter on the next clock edge. With selector 000, `trgo` pulses during the first cycle the counter reads 0. This is one cycle later than the pulse a software restart gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| etr_in | input | 1 | External trigger pin |
| trgo | output | 1 | Selected trigger output |
| oc_ref | output | 4 | Compare reference levels, channels 0 to 3 |

## Verification
Two events can land in the same cycle: the software restart strobe and a counter wrap. The bench watches the update pulses on the trigger output to find the counter phase. It then times a restart write so that the strobe is high while the counter sits at its wrap limit. It judges the result by the output pattern. There must be a single pulse, not two, followed by a full period from zero, and the channel 0 reference must show that the counter restarted at 0.

// File: rtl/timer_trgo_sel.sv
`timescale 1ns/1ps
module timer_trgo_sel #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          etr_in,
  output logic          trgo,
  output logic [3:0]    oc_ref
);
  localparam int NCH = 4;

  logic          sw_run, sync_dly, etr_inv;
  logic [2:0]    msel;
  logic [1:0]    slv_mode;
  logic [CW-1:0] reload, cnt;
  logic [CW-1:0] cmp [NCH];
  logic          ug_p, trig_q, rst_dly;
  logic [NCH-1:0] match;

  wire trig      = etr_in ^ etr_inv;
  wire gated     = (slv_mode == 2'b10);
  wire rmode     = (slv_mode == 2'b01);
  wire trig_rise = trig & ~trig_q;
  wire en_cnt    = sw_run | (gated & (sync_dly ? trig_q : trig));
  wire en_out    = sw_run | (gated & trig_q);
  wire rst_evt   = rmode & trig_rise;
  wire clr       = ug_p | rst_evt;
  wire wrap      = en_cnt & ~clr & (cnt == reload);
  wire upd       = ug_p | wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_run   <= 1'b0;
      msel     <= 3'd0;
      sync_dly <= 1'b0;
      slv_mode <= 2'd0;
      etr_inv  <= 1'b0;
      reload   <= '1;
      ug_p     <= 1'b0;
    end else begin
      ug_p <= wr_en && (wr_addr == AW'(1)) && wr_data[0];
      if (wr_en && wr_addr == AW'(0)) begin
        sw_run   <= wr_data[0];
        msel     <= wr_data[3:1];
        sync_dly <= wr_data[4];
        slv_mode <= wr_data[6:5];
        etr_inv  <= wr_data[7];
      end
      if (wr_en && wr_addr == AW'(2)) reload <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      rst_dly <= 1'b0;
    end else begin
      trig_q  <= trig;
      rst_dly <= rst_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en_cnt) cnt <= (cnt == reload) ? '0 : cnt + CW'(1);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp[i] <= '0;
      else if (wr_en && wr_addr == AW'(4 + i)) cmp[i] <= wr_data;
    end
    assign oc_ref[i] = cnt < cmp[i];
    assign match[i]  = en_cnt & ~clr & (cnt == cmp[i]);
  end

  always_comb begin
    case (msel)
      3'd0:    trgo = ug_p | rst_dly;
      3'd1:    trgo = en_out;
      3'd2:    trgo = upd;
      3'd3:    trgo = match[0];
      default: trgo = oc_ref[msel[1:0]];
    endcase
  end
endmodule

// File: rtl/timer_trgo_chk.sv
`timescale 1ns/1ps
module timer_trgo_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] reload,
  input logic          en_cnt,
  input logic          clr,
  input logic          ug_p,
  input logic          rst_evt,
  input logic [2:0]    msel,
  input logic          wr_en,
  input logic          trgo,
  input logic          sync_dly,
  input logic          gated,
  input logic          sw_run
);
  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cnt && !clr && cnt == reload) |=> (cnt == '0));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cnt && !clr && cnt != reload) |=> (cnt == $past(cnt) + CW'(1)));

  // R4
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ug_p |=> (cnt == '0));

  // R10
  pin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && !ug_p) |=> (cnt == '0));

  // R10
  pin_trgo_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_evt && msel == 3'd0 && !wr_en) |=> trgo);

  // R8
  aligned_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && sync_dly && !sw_run && msel == 3'd1) |-> (trgo == en_cnt));
endmodule

bind timer_trgo_sel timer_trgo_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .reload(reload), .en_cnt(en_cnt),
  .clr(clr), .ug_p(ug_p), .rst_evt(rst_evt), .msel(msel), .wr_en(wr_en),
  .trgo(trgo), .sync_dly(sync_dly), .gated(gated), .sw_run(sw_run)
);

// File: tb/timer_trgo_sel_bench.sv
`timescale 1ns/1ps
module timer_trgo_sel_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, etr_in = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trgo;
  logic [3:0]  oc_ref;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  timer_trgo_sel u_timer_trgo_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .etr_in(etr_in), .trgo(trgo), .oc_ref(oc_ref));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(trgo == 1'b0, "R1 trgo", int'(trgo), 0);
    chk(oc_ref == 4'd0, "R1 oc_ref", int'(oc_ref), 0);
  endtask

  task automatic t_prescale;
    int hits = 0; bit prev = 0, dbl = 0;
    wr(3'd2, 16'd3); wr(3'd0, 16'h0004); wr(3'd1, 16'd1); wr(3'd0, 16'h0005);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (trgo) hits++;
      if (trgo && prev) dbl = 1;
      prev = trgo;
    end
    chk(hits == 10, "R3 update pulses", hits, 10);
    chk(!dbl, "R3 pulse width", int'(dbl), 0);
  endtask

  task automatic t_restart;
    int hits = 0;
    wr(3'd4, 16'd1); wr(3'd2, 16'd100); wr(3'd0, 16'h0001); idle(5);
    wr(3'd0, 16'h0000);
    chk(oc_ref[0] == 1'b0, "R4 counter advanced", int'(oc_ref[0]), 0);
    wr(3'd1, 16'd1);
    for (int k = 0; k < 5; k++) begin
      if (trgo) hits++;
      @(negedge clk);
    end
    chk(hits == 1, "R4 single strobe", hits, 1);
    chk(oc_ref[0] == 1'b1, "R4 counter cleared", int'(oc_ref[0]), 1);
  endtask

  task automatic t_levels;
    int th, rh;
    wr(3'd2, 16'd9);
    for (int i = 0; i < 4; i++) wr(3'(4 + i), 16'(2 * (i + 1)));
    wr(3'd1, 16'd1);
    for (int i = 0; i < 4; i++) begin
      wr(3'd0, 16'(((4 + i) << 1) | 1));
      th = 0; rh = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (trgo) th++;
        if (oc_ref[i]) rh++;
      end
      chk(th == 8 * (i + 1), "R2 selector ref", th, 8 * (i + 1));
      chk(rh == 8 * (i + 1), "R5 ref level", rh, 8 * (i + 1));
    end
  endtask

  task automatic t_match;
    int hits;
    wr(3'd2, 16'd9);
    for (int v = 0; v < 2; v++) begin
      wr(3'd4, v == 0 ? 16'd5 : 16'd0);
      wr(3'd0, 16'h0007);
      hits = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (trgo) hits++;
      end
      chk(hits == 4, "R6 match pulses", hits, 4);
    end
  endtask

  task automatic t_gate(input bit align);
    etr_in = 1'b0;
    wr(3'd2, 16'd1000); wr(3'd4, 16'd3);
    wr(3'd0, align ? 16'h0052 : 16'h0042);
    wr(3'd1, 16'd1); idle(2);
    etr_in = 1'b1;
    #2;
    chk(trgo == 1'b0, align ? "R8 trgo before edge" : "R7 trgo before edge", int'(trgo), 0);
    @(negedge clk);
    chk(trgo == 1'b1, align ? "R8 trgo delayed" : "R7 trgo delayed", int'(trgo), 1);
    idle(2);
    if (align) begin
      chk(oc_ref[0] == 1'b1, "R8 counter aligned", int'(oc_ref[0]), 1);
      @(negedge clk);
      chk(oc_ref[0] == 1'b0, "R8 counter reaches 3", int'(oc_ref[0]), 0);
    end else begin
      chk(oc_ref[0] == 1'b0, "R7 counter early start", int'(oc_ref[0]), 0);
    end
    etr_in = 1'b0;
    idle(2);
  endtask

  task automatic t_invert;
    etr_in = 1'b1;
    wr(3'd2, 16'd1000); wr(3'd4, 16'd3); wr(3'd0, 16'h00C2);
    wr(3'd1, 16'd1); idle(10);
    chk(oc_ref[0] == 1'b1, "R9 inactive high pin holds", int'(oc_ref[0]), 1);
    chk(trgo == 1'b0, "R9 trgo idle", int'(trgo), 0);
    etr_in = 1'b0;
    @(negedge clk);
    chk(trgo == 1'b1, "R9 low pin enables", int'(trgo), 1);
    idle(4);
    chk(oc_ref[0] == 1'b0, "R9 counting", int'(oc_ref[0]), 0);
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_pin_reset;
    etr_in = 1'b0;
    wr(3'd2, 16'd1000); wr(3'd4, 16'd3); wr(3'd0, 16'h0021);
    wr(3'd1, 16'd1); idle(10);
    chk(trgo == 1'b0, "R10 trgo idle", int'(trgo), 0);
    etr_in = 1'b1;
    #2;
    chk(trgo == 1'b0 && oc_ref[0] == 1'b0, "R10 before edge", int'(trgo), 0);
    @(negedge clk);
    chk(oc_ref[0] == 1'b1, "R10 counter cleared", int'(oc_ref[0]), 1);
    chk(trgo == 1'b1, "R10 trgo lag pulse", int'(trgo), 1);
    @(negedge clk);
    chk(trgo == 1'b0, "R10 trgo one cycle", int'(trgo), 0);
    etr_in = 1'b0;
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_collide;
    int guard = 0;
    logic [4:0] seen;
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'd3); wr(3'd4, 16'd1); wr(3'd1, 16'd1);
    wr(3'd0, 16'h0005);
    while (!trgo && guard < 20) begin @(negedge clk); guard++; end
    idle(3);
    wr(3'd1, 16'd1);
    for (int k = 0; k < 5; k++) begin
      seen[k] = trgo;
      if (k == 1) chk(oc_ref[0] == 1'b1, "R4 restart at wrap", int'(oc_ref[0]), 1);
      @(negedge clk);
    end
    chk(seen == 5'b10001, "R4 single update at wrap", int'(seen), 17);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_prescale();
    t_restart();
    t_levels();
    t_match();
    t_gate(1'b0);
    t_gate(1'b1);
    t_invert();
    t_pin_reset();
    t_collide();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule